// File: doc/BRIEF.md
# USB OUT endpoint packet buffer controller

This block sits between a USB serial interface engine and a small control processor. It holds one packet buffer for each OUT endpoint. On the USB side the engine frames each received packet with a start strobe that names the target endpoint, one valid strobe per data byte, and an end strobe. The block then answers with a one-cycle ACK or NACK pulse. A buffer that already holds a packet refuses all later traffic with NACK until software frees it. A packet longer than the buffer is thrown away and leaves an error flag set for that endpoint.

On the processor side, software issues one-byte commands with a command strobe and fetches the data phase one byte per read strobe:

- Selecting an endpoint returns its status byte.
- The read-buffer command streams out the stored length byte and then the payload.
- The clear-buffer command releases the buffer.
- A separate error-status command returns, and then clears, the error flags of all endpoints.

The read position belongs to the selected endpoint. It survives every command except a new select and a clear, so a buffer read can be broken off and picked up again later.

Top module: `usb_epbuf_ctrl`

## Requirements
- R1: After reset every endpoint is empty with no error, `rd_data` is 0x00, `hs_ack` and `hs_nack` are low, and no handshake appears without a packet.
- R2: A packet of 0 to 8 bytes sent to an empty endpoint raises `hs_ack` for exactly the cycle after `rx_end`, and marks that endpoint full.
- R3: A packet sent to a full endpoint raises `hs_nack` for the cycle after `rx_end`. The stored length and bytes stay unchanged. `hs_ack` and `hs_nack` are never high together.
- R4: A packet of more than 8 bytes gives neither ACK nor NACK. It leaves the endpoint empty and sets that endpoint's error flag.
- R5: Command byte n (0x00 to 0x03) selects endpoint n and moves the read position to the start of its buffer. Each later read strobe returns the status byte: bit 0 is full, bit 1 is error, and the other bits are zero.
- R6: After command 0x30 (read buffer), successive read strobes return the stored length first, then the payload bytes in arrival order. Every read past the last payload byte returns 0x00.
- R7: The read position advances by one on each buffer read. Reissuing 0x30, the error-status command or an unknown opcode does not move it. Only a select (R5) or a clear (R8) moves it back to the start.
- R8: Command 0x31 (clear buffer) empties the selected endpoint and sets its length to zero. A later packet to that endpoint is accepted with ACK.
- R9: After command 0x32 (error status), a read strobe returns a byte whose bit n is the error flag of endpoint n. That read clears all error flags, so a second read returns 0x00.
- R10: A packet for one endpoint changes neither the full flag nor the error flag of any other endpoint.
- R11: `rd_data` changes only in the cycle after a read strobe and holds its value otherwise. A read strobe with no select, buffer or error-status command active returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_start | input | 1 | Start of a received packet; latches `rx_ep` |
| rx_ep | input | 2 | Target OUT endpoint of the packet |
| rx_valid | input | 1 | One received byte on `rx_data` |
| rx_data | input | 8 | Received byte |
| rx_end | input | 1 | End of the received packet |
| hs_ack | output | 1 | One-cycle ACK pulse |
| hs_nack | output | 1 | One-cycle NACK pulse |
| cmd_stb | input | 1 | Command strobe |
| cmd_op | input | 8 | Command opcode |
| rd_stb | input | 1 | Data-phase read strobe |
| rd_data | output | 8 | Data-phase read byte, registered |

## Verification
The hardest situation to reach is a buffer read that has been broken off partway and then resumed. It needs a full endpoint, a read position in the middle of the payload, and other commands issued between the reads. The bench builds this on purpose. It fills one endpoint, reads part of the payload, and then issues a repeated read-buffer command, an error-status read and an unknown opcode between byte reads, checking each time that the next payload byte follows on. Separately, a sweep over every endpoint and every length from 0 to 9 covers refusal of a full buffer, the oversize discard with its error flag, and whether the other endpoints stay untouched.

// File: rtl/epbuf_pkg.sv
package epbuf_pkg;

  localparam logic [7:0] OP_RDBUF   = 8'h30;
  localparam logic [7:0] OP_CLRBUF  = 8'h31;
  localparam logic [7:0] OP_ERRSTAT = 8'h32;

  typedef enum logic [1:0] {
    MD_IDLE = 2'd0,
    MD_SEL  = 2'd1,
    MD_BUF  = 2'd2,
    MD_ERR  = 2'd3
  } cmd_mode_e;

  function automatic logic [7:0] status_byte(input logic full, input logic err);
    return {6'b000000, err, full};
  endfunction

endpackage

// File: rtl/epbuf_rx.sv
module epbuf_rx #(
  parameter int NUM_EP  = 4,
  parameter int MAX_PKT = 8,
  localparam int EPW = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
  localparam int IW  = $clog2(MAX_PKT + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_start,
  input  logic [EPW-1:0]    rx_ep,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_end,
  input  logic [NUM_EP-1:0] full_vec,
  output logic              wr_en,
  output logic [EPW-1:0]    cur_ep,
  output logic [IW-1:0]     wr_idx,
  output logic [7:0]        wr_byte,
  output logic              commit,
  output logic              oversize,
  output logic [IW-1:0]     pkt_len,
  output logic              hs_ack,
  output logic              hs_nack
);

  localparam logic [IW-1:0] CNT_MAX = IW'(MAX_PKT);
  localparam logic [IW-1:0] CNT_SAT = IW'(MAX_PKT + 1);

  logic          busy_q;
  logic          drop_q;
  logic [IW-1:0] cnt_q;
  logic          end_evt;

  function automatic logic [IW-1:0] cnt_step(input logic [IW-1:0] c);
    return (c == CNT_SAT) ? c : c + 1'b1;
  endfunction

  assign end_evt  = busy_q && rx_end;
  assign wr_en    = busy_q && rx_valid && !drop_q && (cnt_q < CNT_MAX);
  assign wr_idx   = cnt_q;
  assign wr_byte  = rx_data;
  assign commit   = end_evt && !drop_q && (cnt_q <= CNT_MAX);
  assign oversize = end_evt && !drop_q && (cnt_q > CNT_MAX);
  assign pkt_len  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      drop_q  <= 1'b0;
      cnt_q   <= '0;
      cur_ep  <= '0;
      hs_ack  <= 1'b0;
      hs_nack <= 1'b0;
    end else begin
      hs_ack  <= commit;
      hs_nack <= end_evt && drop_q;
      if (rx_start) begin
        busy_q <= 1'b1;
        cur_ep <= rx_ep;
        drop_q <= full_vec[rx_ep];
        cnt_q  <= '0;
      end else if (end_evt) begin
        busy_q <= 1'b0;
      end else if (busy_q && rx_valid) begin
        cnt_q <= cnt_step(cnt_q);
      end
    end
  end

endmodule

// File: rtl/epbuf_store.sv
module epbuf_store #(
  parameter int NUM_EP  = 4,
  parameter int MAX_PKT = 8,
  localparam int EPW = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
  localparam int IW  = $clog2(MAX_PKT + 2),
  localparam int AW  = (MAX_PKT > 1) ? $clog2(MAX_PKT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [EPW-1:0]    wr_ep,
  input  logic [IW-1:0]     wr_idx,
  input  logic [7:0]        wr_byte,
  input  logic              commit,
  input  logic              oversize,
  input  logic [IW-1:0]     pkt_len,
  input  logic              clr,
  input  logic [EPW-1:0]    clr_ep,
  input  logic              err_clr,
  input  logic [EPW-1:0]    rd_ep,
  input  logic [IW-1:0]     rd_idx,
  output logic [NUM_EP-1:0] full_vec,
  output logic [NUM_EP-1:0] err_vec,
  output logic [7:0]        rd_byte
);

  logic [7:0]    mem_q [NUM_EP][MAX_PKT];
  logic [IW-1:0] len_q [NUM_EP];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_ep][wr_idx[AW-1:0]] <= wr_byte;
  end

  for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        full_vec[g] <= 1'b0;
        len_q[g]    <= '0;
      end else if (commit && wr_ep == EPW'(g)) begin
        full_vec[g] <= 1'b1;
        len_q[g]    <= pkt_len;
      end else if (clr && clr_ep == EPW'(g)) begin
        full_vec[g] <= 1'b0;
        len_q[g]    <= '0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             err_vec[g] <= 1'b0;
      else if (oversize && wr_ep == EPW'(g))  err_vec[g] <= 1'b1;
      else if (err_clr)                       err_vec[g] <= 1'b0;
    end
  end

  logic [IW-1:0] sel_len;
  logic [IW-1:0] pay_idx;

  always_comb begin
    sel_len = len_q[rd_ep];
    pay_idx = rd_idx - 1'b1;
    if (rd_idx == '0)            rd_byte = 8'(sel_len);
    else if (rd_idx <= sel_len)  rd_byte = mem_q[rd_ep][pay_idx[AW-1:0]];
    else                         rd_byte = 8'h00;
  end

endmodule

// File: rtl/epbuf_cmd.sv
module epbuf_cmd
  import epbuf_pkg::*;
#(
  parameter int NUM_EP  = 4,
  parameter int MAX_PKT = 8,
  localparam int EPW = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
  localparam int IW  = $clog2(MAX_PKT + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_stb,
  input  logic [7:0]        cmd_op,
  input  logic              rd_stb,
  input  logic [NUM_EP-1:0] full_vec,
  input  logic [NUM_EP-1:0] err_vec,
  input  logic [7:0]        buf_byte,
  output logic [7:0]        rd_data,
  output logic [EPW-1:0]    sel_ep,
  output logic [IW-1:0]     ptr,
  output logic              clr,
  output logic              err_clr,
  output logic              sel_hit,
  output logic              mode_buf
);

  localparam logic [IW-1:0] PTR_LIM = IW'(MAX_PKT + 1);

  cmd_mode_e  mode_q;
  logic       rd_go;
  logic [7:0] err_byte;

  function automatic logic [IW-1:0] ptr_step(input logic [IW-1:0] p);
    return (p == PTR_LIM) ? p : p + 1'b1;
  endfunction

  assign sel_hit  = cmd_stb && (cmd_op < 8'(NUM_EP));
  assign clr      = cmd_stb && (cmd_op == OP_CLRBUF);
  assign rd_go    = rd_stb && !cmd_stb;
  assign err_clr  = rd_go && (mode_q == MD_ERR);
  assign mode_buf = (mode_q == MD_BUF);

  always_comb begin
    err_byte = 8'h00;
    err_byte[NUM_EP-1:0] = err_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MD_IDLE;
      sel_ep  <= '0;
      ptr     <= '0;
      rd_data <= 8'h00;
    end else if (cmd_stb) begin
      if (sel_hit) begin
        sel_ep <= cmd_op[EPW-1:0];
        ptr    <= '0;
        mode_q <= MD_SEL;
      end else if (cmd_op == OP_RDBUF) begin
        mode_q <= MD_BUF;
      end else if (cmd_op == OP_CLRBUF) begin
        ptr    <= '0;
        mode_q <= MD_IDLE;
      end else if (cmd_op == OP_ERRSTAT) begin
        mode_q <= MD_ERR;
      end
    end else if (rd_go) begin
      unique case (mode_q)
        MD_SEL:  rd_data <= status_byte(full_vec[sel_ep], err_vec[sel_ep]);
        MD_BUF: begin
          rd_data <= buf_byte;
          ptr     <= ptr_step(ptr);
        end
        MD_ERR:  rd_data <= err_byte;
        default: rd_data <= 8'h00;
      endcase
    end
  end

endmodule

// File: rtl/usb_epbuf_ctrl.sv
module usb_epbuf_ctrl #(
  parameter int NUM_EP  = 4,
  parameter int MAX_PKT = 8,
  localparam int EPW = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
  localparam int IW  = $clog2(MAX_PKT + 2)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           rx_start,
  input  logic [EPW-1:0] rx_ep,
  input  logic           rx_valid,
  input  logic [7:0]     rx_data,
  input  logic           rx_end,
  output logic           hs_ack,
  output logic           hs_nack,
  input  logic           cmd_stb,
  input  logic [7:0]     cmd_op,
  input  logic           rd_stb,
  output logic [7:0]     rd_data
);

  logic              wr_en;
  logic [EPW-1:0]    cur_ep;
  logic [IW-1:0]     wr_idx;
  logic [7:0]        wr_byte;
  logic              commit;
  logic              oversize;
  logic [IW-1:0]     pkt_len;
  logic [NUM_EP-1:0] full_vec;
  logic [NUM_EP-1:0] err_vec;
  logic [EPW-1:0]    sel_ep;
  logic [IW-1:0]     ptr;
  logic              clr;
  logic              err_clr;
  logic              sel_hit;
  logic              mode_buf;
  logic [7:0]        buf_byte;

  epbuf_rx #(.NUM_EP(NUM_EP), .MAX_PKT(MAX_PKT)) rx_i (
    .clk(clk), .rst_n(rst_n),
    .rx_start(rx_start), .rx_ep(rx_ep), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_end(rx_end), .full_vec(full_vec),
    .wr_en(wr_en), .cur_ep(cur_ep), .wr_idx(wr_idx), .wr_byte(wr_byte),
    .commit(commit), .oversize(oversize), .pkt_len(pkt_len),
    .hs_ack(hs_ack), .hs_nack(hs_nack)
  );

  epbuf_store #(.NUM_EP(NUM_EP), .MAX_PKT(MAX_PKT)) store_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_ep(cur_ep), .wr_idx(wr_idx), .wr_byte(wr_byte),
    .commit(commit), .oversize(oversize), .pkt_len(pkt_len),
    .clr(clr), .clr_ep(sel_ep), .err_clr(err_clr),
    .rd_ep(sel_ep), .rd_idx(ptr),
    .full_vec(full_vec), .err_vec(err_vec), .rd_byte(buf_byte)
  );

  epbuf_cmd #(.NUM_EP(NUM_EP), .MAX_PKT(MAX_PKT)) cmd_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_stb(cmd_stb), .cmd_op(cmd_op), .rd_stb(rd_stb),
    .full_vec(full_vec), .err_vec(err_vec), .buf_byte(buf_byte),
    .rd_data(rd_data), .sel_ep(sel_ep), .ptr(ptr), .clr(clr),
    .err_clr(err_clr), .sel_hit(sel_hit), .mode_buf(mode_buf)
  );

endmodule

// File: rtl/epbuf_chk.sv
module epbuf_chk #(
  parameter int NUM_EP  = 4,
  parameter int MAX_PKT = 8,
  localparam int EPW = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
  localparam int IW  = $clog2(MAX_PKT + 2)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hs_ack,
  input logic              hs_nack,
  input logic              commit,
  input logic              oversize,
  input logic [EPW-1:0]    cur_ep,
  input logic [IW-1:0]     pkt_len,
  input logic [NUM_EP-1:0] full_vec,
  input logic [NUM_EP-1:0] err_vec,
  input logic              cmd_stb,
  input logic              rd_stb,
  input logic              mode_buf,
  input logic              sel_hit,
  input logic [IW-1:0]     ptr,
  input logic [7:0]        rd_data
);

  localparam logic [IW-1:0] PTR_LIM = IW'(MAX_PKT + 1);

  // R2
  ack_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> hs_ack);

  // R2
  len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (pkt_len <= IW'(MAX_PKT)));

  // R3
  hs_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hs_ack, hs_nack}));

  // R4
  oversize_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oversize |=> (err_vec[$past(cur_ep)] && !full_vec[$past(cur_ep)]));

  // R5
  sel_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_hit |=> (ptr == '0));

  // R7
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !cmd_stb && mode_buf && ptr != PTR_LIM) |=> (ptr == $past(ptr) + 1'b1));

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_stb) |-> $stable(rd_data));

  for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
    // R10
    full_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(full_vec[g]) |-> $past(commit && cur_ep == EPW'(g)));
  end

endmodule

bind usb_epbuf_ctrl epbuf_chk #(.NUM_EP(NUM_EP), .MAX_PKT(MAX_PKT)) chk_i (
  .clk(clk), .rst_n(rst_n), .hs_ack(hs_ack), .hs_nack(hs_nack),
  .commit(commit), .oversize(oversize), .cur_ep(cur_ep), .pkt_len(pkt_len),
  .full_vec(full_vec), .err_vec(err_vec), .cmd_stb(cmd_stb), .rd_stb(rd_stb),
  .mode_buf(mode_buf), .sel_hit(sel_hit), .ptr(ptr), .rd_data(rd_data)
);

// File: tb/usb_epbuf_ctrl_tb_top.sv
module usb_epbuf_ctrl_tb_top;

  localparam int NEP  = 4;
  localparam int MAXP = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_start = 1'b0, rx_valid = 1'b0, rx_end = 1'b0;
  logic [1:0] rx_ep = 2'd0;
  logic [7:0] rx_data = 8'h00;
  logic       hs_ack, hs_nack;
  logic       cmd_stb = 1'b0, rd_stb = 1'b0;
  logic [7:0] cmd_op = 8'h00;
  logic [7:0] rd_data;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;
  logic got_ack, got_nack;
  logic [7:0] rv;

  always #4 clk = ~clk;

  usb_epbuf_ctrl #(.NUM_EP(NEP), .MAX_PKT(MAXP)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .rx_start(rx_start), .rx_ep(rx_ep), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_end(rx_end), .hs_ack(hs_ack), .hs_nack(hs_nack),
    .cmd_stb(cmd_stb), .cmd_op(cmd_op), .rd_stb(rd_stb), .rd_data(rd_data)
  );

  function automatic logic [7:0] pbyte(input int ep, input int i, input int seed);
    return 8'(ep * 37 + i * 11 + seed * 101 + 5);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic send_pkt(input int ep, input int n, input int seed);
    rx_start = 1'b1; rx_ep = 2'(ep);
    @(negedge clk);
    rx_start = 1'b0;
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1; rx_data = pbyte(ep, i, seed);
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_end = 1'b1;
    @(negedge clk);
    rx_end = 1'b0;
    got_ack = hs_ack; got_nack = hs_nack;
    @(negedge clk);
  endtask

  task automatic cmd(input logic [7:0] op);
    cmd_op = op; cmd_stb = 1'b1;
    @(negedge clk);
    cmd_stb = 1'b0;
  endtask

  task automatic rd(output logic [7:0] v);
    rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    v = rd_data;
  endtask

  task automatic check_buffer(input string req, input int ep, input int n, input int seed);
    logic [7:0] v;
    int exp;
    cmd(8'(ep));
    cmd(8'h30);
    for (int i = 0; i < MAXP + 3; i++) begin
      rd(v);
      if (i == 0)      exp = n;
      else if (i <= n) exp = pbyte(ep, i - 1, seed);
      else             exp = 0;
      chk(req, v, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 rd_data", rd_data, 0);
    chk("R1 handshake", {hs_ack, hs_nack}, 0);
    rd(rv); chk("R1 idle read", rv, 0);
    for (int e = 0; e < NEP; e++) begin
      cmd(8'(e)); rd(rv); chk("R1 status", rv, 0);
    end
    cmd(8'h32); rd(rv); chk("R1 errors", rv, 0);

    // Sweep every endpoint over lengths 0..MAXP+1
    for (int e = 0; e < NEP; e++) begin
      for (int n = 0; n <= MAXP + 1; n++) begin
        send_pkt(e, n, 0);
        if (n <= MAXP) begin
          chk("R2 ack", {got_ack, got_nack}, 2);
          cmd(8'(e)); rd(rv); chk("R2 full status", rv, 1);
        end else begin
          chk("R4 no handshake", {got_ack, got_nack}, 0);
          cmd(8'(e)); rd(rv); chk("R4 error status", rv, 2);
        end
        cmd(8'((e + 1) % NEP)); rd(rv); chk("R10 other endpoint", rv, 0);
        if (n <= MAXP) begin
          check_buffer("R6 buffer read", e, n, 0);
          send_pkt(e, (n + 3) % (MAXP + 1), 1);
          chk("R3 nack", {got_ack, got_nack}, 1);
          check_buffer("R3 contents kept", e, n, 0);
        end else begin
          check_buffer("R4 discarded", e, 0, 0);
          cmd(8'h32); rd(rv); chk("R9 error mask", rv, 1 << e);
          rd(rv); chk("R9 cleared", rv, 0);
        end
        cmd(8'(e)); cmd(8'h31);
        // R11: the clear command leaves rd_data as it was, then an idle read gives 0
        chk("R11 hold", rd_data, (n <= MAXP) ? 0 : 0);
        rd(rv); chk("R11 idle read", rv, 0);
        cmd(8'(e)); rd(rv); chk("R8 cleared", rv, 0);
      end
    end

    // R7: interrupted read resumes
    send_pkt(2, 6, 3);
    chk("R8 accept after clear", {got_ack, got_nack}, 2);
    cmd(8'd2); cmd(8'h30);
    rd(rv); chk("R7 len", rv, 6);
    rd(rv); chk("R7 b0", rv, pbyte(2, 0, 3));
    rd(rv); chk("R7 b1", rv, pbyte(2, 1, 3));
    cmd(8'h30);
    rd(rv); chk("R7 b2 after reissue", rv, pbyte(2, 2, 3));
    repeat (3) @(negedge clk);
    chk("R11 stable", rd_data, pbyte(2, 2, 3));
    cmd(8'h32);
    rd(rv); chk("R7 error status between", rv, 0);
    cmd(8'h30);
    rd(rv); chk("R7 b3 after status", rv, pbyte(2, 3, 3));
    cmd(8'h7F);
    chk("R11 stable on command", rd_data, pbyte(2, 3, 3));
    rd(rv); chk("R7 b4 after unknown op", rv, pbyte(2, 4, 3));
    cmd(8'd2); rd(rv); chk("R5 status", rv, 1);
    cmd(8'h30);
    rd(rv); chk("R5 rewind", rv, 6);
    cmd(8'h31); cmd(8'h30);
    rd(rv); chk("R8 rewind and empty", rv, 0);

    // R10: fill two endpoints, the rest stay empty
    send_pkt(1, 4, 2);
    send_pkt(3, MAXP + 1, 2);
    cmd(8'd0); rd(rv); chk("R10 ep0", rv, 0);
    cmd(8'd1); rd(rv); chk("R10 ep1", rv, 1);
    cmd(8'd2); rd(rv); chk("R10 ep2", rv, 0);
    cmd(8'd3); rd(rv); chk("R10 ep3", rv, 2);
    check_buffer("R6 ep1", 1, 4, 2);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule